// File: doc/BRIEF.md
# Anode Wire Hit Shaper and Pretrigger

This block watches one key wire group of a six-layer wire chamber. Every bunch crossing it receives one hit strobe for each wire of a small window of neighbouring wire groups on each layer. Each wire has a hit shaper. The shaper filters the raw strobes with a continuation rule and a dead time. It then stretches every accepted hit into an active window of fixed length. A programmable mask picks which wires of the window take part. A layer counts as hit when any of its masked wires is active in the current crossing.

When the number of hit layers reaches the pretrigger threshold, the block issues a pretrigger. The pretrigger carries the crossing number, the layer count and the key wire index. After a programmable drift delay, the block samples the layer count again and reports it as the pattern quality. The quality is forced to zero when the count is below the pattern threshold. Crossings are numbered within a 32-crossing frame. The frame restarts on a frame-start strobe or when the crossing number wraps. The two pattern kinds, collision and accelerator, each have their own pair of thresholds.

Top module: `wire_pretrig`

## Requirements
- R1: A hit on a wire is ignored when the same wire also had a hit in the immediately preceding crossing of the frame, even after the dead time has expired.
- R2: A hit on a wire is accepted only if at least 6 crossings separate it from the previous accepted hit on that wire; the first hit of a frame is always eligible.
- R3: An accepted hit at crossing b keeps its wire active in crossings b through b+HIT_PERSIST-1 (default 6), and in no other crossing.
- R4: An accepted hit at crossing b with b+HIT_PERSIST of 32 or more produces no active window.
- R5: A pretrigger fires in a crossing whose count of distinct layers with at least one active masked wire is at least the selected pretrigger threshold. One clock after that crossing, pretrig_o pulses for one cycle, and bx_o, layers_o and key_wire_o show that crossing's number (0 at frame start), its layer count and key_wire_i. Several active wires on one layer count once.
- R6: A wire whose mask bit is 0 never contributes to the layer count. Hit bit l*NUM_WIRES+w and mask bit l*NUM_WIRES+w belong to layer l, wire w.
- R7: kind_i=1 selects the accelerator thresholds and kind_i=0 selects the collision thresholds, both for the pretrigger and for the pattern.
- R8: With drift delay D (0..3), result_o pulses one clock after crossing p+D, where p is the pretrigger crossing. quality_o then holds the layer count of crossing p+D.
- R9: When that count is below the pattern threshold latched at the pretrigger, result_o still pulses and quality_o is 0.
- R10: After a pretrigger, no further pretrigger fires in crossings p+1 through p+D, so each pretrigger yields exactly one result.
- R11: After reset, pretrig_o, result_o and quality_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Marks the current crossing as crossing 0 of a new frame |
| hit_i | input | NUM_LAYERS*NUM_WIRES | Raw hit strobes, bit l*NUM_WIRES+w |
| mask_i | input | NUM_LAYERS*NUM_WIRES | Pattern mask, same bit layout as hit_i |
| kind_i | input | 1 | 1 = accelerator thresholds, 0 = collision thresholds |
| pre_thr_coll_i | input | 3 | Collision pretrigger layer threshold |
| pre_thr_acc_i | input | 3 | Accelerator pretrigger layer threshold |
| pat_thr_coll_i | input | 3 | Collision pattern layer threshold |
| pat_thr_acc_i | input | 3 | Accelerator pattern layer threshold |
| drift_i | input | 2 | Drift delay in crossings |
| key_wire_i | input | KEY_W | Index of the evaluated key wire group |
| pretrig_o | output | 1 | Pretrigger pulse |
| key_wire_o | output | KEY_W | Key wire index captured at pretrigger |
| bx_o | output | 5 | Crossing number of the pretrigger |
| layers_o | output | 3 | Layer count at the pretrigger |
| result_o | output | 1 | Pattern result pulse |
| quality_o | output | 3 | Pattern quality (layer count, or 0 below threshold) |

## Verification
A shaper whose dead-time or continuation state is wrong shows up as extra or missing pretrigger pulses. These appear in the crossings right after the offending hit, because each active crossing of a lone wire produces its own pulse when the threshold is one and the drift delay is zero. A wrong stretch counter moves the first or last pulse of such a run by exactly one crossing. A wrong wait counter in the evaluation control moves result_o away from crossing p+D, or lets a second pretrigger through inside the wait. Each of these can be seen within at most four crossings of the pretrigger.

// File: rtl/wire_trig_pkg.sv
package wire_trig_pkg;
  localparam int NUM_LAYERS = 6;
  localparam int THR_W      = 3;
  localparam int DRIFT_W    = 2;
  localparam int FRAME_LEN  = 32;
  localparam int BX_W       = $clog2(FRAME_LEN);
  localparam int CNT_W      = $clog2(NUM_LAYERS + 1);

  typedef logic [BX_W-1:0]    bx_t;
  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [THR_W-1:0]   thr_t;
  typedef logic [DRIFT_W-1:0] drift_t;
endpackage

// File: rtl/hit_shaper.sv
module hit_shaper
  import wire_trig_pkg::*;
#(
  parameter int HIT_PERSIST = 6,
  parameter int DEAD_TIME   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  bx_t  bx_i,
  input  logic fresh_i,
  output logic active_o
);
  localparam int SINCE_W    = $clog2(DEAD_TIME + 1);
  localparam int HOLD_W     = $clog2(HIT_PERSIST + 1);
  localparam int LAST_START = FRAME_LEN - HIT_PERSIST;
  localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(DEAD_TIME);
  localparam logic [HOLD_W-1:0]  HOLD_LOAD = HOLD_W'(HIT_PERSIST - 1);

  logic               prev_q;
  logic [SINCE_W-1:0] since_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               accept, stretch;

  // continuation and dead-time filter; state is void at frame start
  assign accept   = hit_i & ~(prev_q & ~fresh_i) & (fresh_i | (since_q >= SINCE_MAX));
  assign stretch  = accept & (int'(bx_i) < LAST_START);
  assign active_o = stretch | (~fresh_i & (hold_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      since_q <= SINCE_MAX;
      hold_q  <= '0;
    end else begin
      prev_q <= hit_i;
      if (accept)                 since_q <= SINCE_W'(1);
      else if (fresh_i)           since_q <= SINCE_MAX;
      else if (since_q < SINCE_MAX) since_q <= since_q + SINCE_W'(1);
      if (stretch)                hold_q <= HOLD_LOAD;
      else if (fresh_i)           hold_q <= '0;
      else if (hold_q != '0)      hold_q <= hold_q - HOLD_W'(1);
    end
  end

  // R1: a hit right after a hit cannot open a new window
  a_r1_continuation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !active_o) |=> !(hit_i && !fresh_i && active_o));

  // R4: no window reaches the last crossing of a frame
  a_r4_window_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bx_i == bx_t'(FRAME_LEN - 1)) |-> !active_o);
endmodule

// File: rtl/layer_coinc.sv
module layer_coinc
  import wire_trig_pkg::*;
#(
  parameter int NUM_WIRES = 5
) (
  input  logic [NUM_LAYERS*NUM_WIRES-1:0] active_i,
  input  logic [NUM_LAYERS*NUM_WIRES-1:0] mask_i,
  output cnt_t                            count_o
);
  logic [NUM_LAYERS-1:0] layer_hit;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    assign layer_hit[l] = |(active_i[l*NUM_WIRES +: NUM_WIRES] & mask_i[l*NUM_WIRES +: NUM_WIRES]);
  end

  assign count_o = CNT_W'($countones(layer_hit));
endmodule

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import wire_trig_pkg::*;
#(
  parameter int KEY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_t             count_i,
  input  bx_t              bx_i,
  input  logic             kind_i,
  input  thr_t             pre_thr_coll_i,
  input  thr_t             pre_thr_acc_i,
  input  thr_t             pat_thr_coll_i,
  input  thr_t             pat_thr_acc_i,
  input  drift_t           drift_i,
  input  logic [KEY_W-1:0] key_wire_i,
  output logic             pretrig_o,
  output logic [KEY_W-1:0] key_wire_o,
  output bx_t              bx_o,
  output cnt_t             layers_o,
  output logic             result_o,
  output cnt_t             quality_o
);
  logic   busy_q;
  drift_t wait_q;
  thr_t   pthr_q;
  thr_t   pre_thr, pat_thr, thr_use;
  logic   fire, eval_now;

  assign pre_thr  = kind_i ? pre_thr_acc_i : pre_thr_coll_i;
  assign pat_thr  = kind_i ? pat_thr_acc_i : pat_thr_coll_i;
  assign fire     = ~busy_q & (int'(count_i) >= int'(pre_thr));
  assign eval_now = (fire & (drift_i == '0)) | (busy_q & (wait_q == drift_t'(1)));
  assign thr_use  = fire ? pat_thr : pthr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      wait_q     <= '0;
      pthr_q     <= '0;
      pretrig_o  <= 1'b0;
      key_wire_o <= '0;
      bx_o       <= '0;
      layers_o   <= '0;
      result_o   <= 1'b0;
      quality_o  <= '0;
    end else begin
      pretrig_o <= fire;
      result_o  <= eval_now;
      if (fire) begin
        bx_o       <= bx_i;
        layers_o   <= count_i;
        key_wire_o <= key_wire_i;
        pthr_q     <= pat_thr;
      end
      if (eval_now)
        quality_o <= (int'(count_i) >= int'(thr_use)) ? count_i : '0;
      if (fire && drift_i != '0) begin
        busy_q <= 1'b1;
        wait_q <= drift_i;
      end else if (busy_q) begin
        wait_q <= wait_q - drift_t'(1);
        if (wait_q == drift_t'(1)) busy_q <= 1'b0;
      end
    end
  end

  // R5: reported layer count met the threshold in force at the pretrigger
  a_r5_pretrig_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pretrig_o |-> int'(layers_o) >= int'($past(pre_thr)));

  // R9: a nonzero quality never lies below the latched pattern threshold
  a_r9_quality_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o && quality_o != '0) |-> int'(quality_o) >= int'($past(thr_use)));

  // R10: a pending evaluation blocks the next pretrigger
  a_r10_single_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pretrig_o && !result_o) |=> !pretrig_o);
endmodule

// File: rtl/wire_pretrig.sv
module wire_pretrig
  import wire_trig_pkg::*;
#(
  parameter int NUM_WIRES   = 5,
  parameter int HIT_PERSIST = 6,
  parameter int DEAD_TIME   = 6,
  parameter int KEY_W       = 7
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            frame_start_i,
  input  logic [NUM_LAYERS*NUM_WIRES-1:0] hit_i,
  input  logic [NUM_LAYERS*NUM_WIRES-1:0] mask_i,
  input  logic                            kind_i,
  input  logic [THR_W-1:0]                pre_thr_coll_i,
  input  logic [THR_W-1:0]                pre_thr_acc_i,
  input  logic [THR_W-1:0]                pat_thr_coll_i,
  input  logic [THR_W-1:0]                pat_thr_acc_i,
  input  logic [DRIFT_W-1:0]              drift_i,
  input  logic [KEY_W-1:0]                key_wire_i,
  output logic                            pretrig_o,
  output logic [KEY_W-1:0]                key_wire_o,
  output logic [BX_W-1:0]                 bx_o,
  output logic [CNT_W-1:0]                layers_o,
  output logic                            result_o,
  output logic [CNT_W-1:0]                quality_o
);
  localparam int NUM_CELLS = NUM_LAYERS * NUM_WIRES;

  bx_t                  bx_q, cur_bx;
  logic                 fresh;
  logic [NUM_CELLS-1:0] active;
  cnt_t                 count;

  assign cur_bx = frame_start_i ? '0 : bx_q + bx_t'(1);
  assign fresh  = (cur_bx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bx_q <= bx_t'(FRAME_LEN - 1);
    else         bx_q <= cur_bx;
  end

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_l
    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_w
      hit_shaper #(.HIT_PERSIST(HIT_PERSIST), .DEAD_TIME(DEAD_TIME)) u_shaper (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_i    (hit_i[l*NUM_WIRES+w]),
        .bx_i     (cur_bx),
        .fresh_i  (fresh),
        .active_o (active[l*NUM_WIRES+w])
      );
    end
  end

  layer_coinc #(.NUM_WIRES(NUM_WIRES)) u_coinc (
    .active_i (active),
    .mask_i   (mask_i),
    .count_o  (count)
  );

  pretrig_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .count_i        (count),
    .bx_i           (cur_bx),
    .kind_i         (kind_i),
    .pre_thr_coll_i (pre_thr_coll_i),
    .pre_thr_acc_i  (pre_thr_acc_i),
    .pat_thr_coll_i (pat_thr_coll_i),
    .pat_thr_acc_i  (pat_thr_acc_i),
    .drift_i        (drift_i),
    .key_wire_i     (key_wire_i),
    .pretrig_o      (pretrig_o),
    .key_wire_o     (key_wire_o),
    .bx_o           (bx_o),
    .layers_o       (layers_o),
    .result_o       (result_o),
    .quality_o      (quality_o)
  );
endmodule

// File: tb/wire_pretrig_test.sv
`timescale 1ns/1ps
module wire_pretrig_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 5;
  localparam int NL = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [29:0]   hit = '0;
  logic [29:0]   mask = '1;
  logic          kind = 1'b0;
  logic [2:0]    pc = 3'd1, pa = 3'd1, tc = 3'd1, ta = 3'd1;
  logic [1:0]    drift = 2'd0;
  logic [6:0]    key = 7'd45;
  logic          pretrig, result;
  logic [6:0]    key_o;
  logic [4:0]    bx_o;
  logic [2:0]    layers, quality;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [29:0] hv [32];
  logic        pr [32];
  logic        rs [32];
  logic [4:0]  bxr [32];
  logic [2:0]  lyr [32];
  logic [2:0]  ql [32];
  logic [6:0]  kwr [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  wire_pretrig uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .hit_i(hit), .mask_i(mask),
    .kind_i(kind), .pre_thr_coll_i(pc), .pre_thr_acc_i(pa), .pat_thr_coll_i(tc),
    .pat_thr_acc_i(ta), .drift_i(drift), .key_wire_i(key), .pretrig_o(pretrig),
    .key_wire_o(key_o), .bx_o(bx_o), .layers_o(layers), .result_o(result), .quality_o(quality)
  );

  function automatic int idx(int l, int w);
    return l*NW + w;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(logic fs, logic [29:0] h);
    @(negedge clk);
    frame_start = fs;
    hit = h;
    @(posedge clk);
    #1;
  endtask

  task automatic clear_hv();
    for (int c = 0; c < 32; c++) hv[c] = '0;
  endtask

  task automatic cfg(logic k, int p_c, int p_a, int t_c, int t_a, int d);
    kind = k; pc = 3'(p_c); pa = 3'(p_a); tc = 3'(t_c); ta = 3'(t_a); drift = 2'(d);
    mask = '1;
  endtask

  task automatic run_frame();
    for (int c = 0; c < 32; c++) begin
      step(c == 0, hv[c]);
      pr[c] = pretrig; rs[c] = result; bxr[c] = bx_o;
      lyr[c] = layers; ql[c] = quality; kwr[c] = key_o;
    end
    for (int c = 0; c < 4; c++) step(1'b0, '0);
  endtask

  task automatic t_reset();
    chk("R11 pretrig", pretrig, 0);
    chk("R11 result", result, 0);
    chk("R11 quality", quality, 0);
  endtask

  task automatic t_stretch();
    cfg(0, 1, 1, 1, 1, 0);
    clear_hv(); hv[2][idx(0,2)] = 1'b1;
    run_frame();
    for (int c = 0; c < 32; c++) chk($sformatf("R3 bx%0d", c), pr[c], (c >= 2 && c <= 7));
    chk("R5 bx_o", bxr[2], 2);
    chk("R5 bx_o last", bxr[7], 7);
  endtask

  task automatic t_continuation();
    cfg(0, 1, 1, 1, 1, 0);
    clear_hv();
    for (int c = 10; c <= 17; c++) hv[c][idx(1,0)] = 1'b1;
    run_frame();
    for (int c = 8; c < 20; c++) chk($sformatf("R1 bx%0d", c), pr[c], (c >= 10 && c <= 15));
  endtask

  task automatic t_dead_time();
    cfg(0, 1, 1, 1, 1, 0);
    clear_hv(); hv[2][idx(2,3)] = 1'b1; hv[7][idx(2,3)] = 1'b1;
    run_frame();
    for (int c = 0; c < 16; c++) chk($sformatf("R2 gap5 bx%0d", c), pr[c], (c >= 2 && c <= 7));
    clear_hv(); hv[2][idx(2,3)] = 1'b1; hv[8][idx(2,3)] = 1'b1;
    run_frame();
    for (int c = 0; c < 16; c++) chk($sformatf("R2 gap6 bx%0d", c), pr[c], (c >= 2 && c <= 13));
  endtask

  task automatic t_range();
    cfg(0, 1, 1, 1, 1, 0);
    clear_hv(); hv[26][idx(5,1)] = 1'b1;
    run_frame();
    for (int c = 24; c < 32; c++) chk($sformatf("R4 late bx%0d", c), pr[c], 0);
    clear_hv(); hv[25][idx(5,1)] = 1'b1;
    run_frame();
    for (int c = 24; c < 32; c++) chk($sformatf("R4 edge bx%0d", c), pr[c], (c >= 25 && c <= 30));
  endtask

  task automatic t_layers_mask();
    cfg(0, 3, 7, 3, 7, 0);
    mask[idx(2,4)] = 1'b0;
    clear_hv();
    hv[4][idx(0,0)] = 1'b1; hv[4][idx(0,1)] = 1'b1; hv[4][idx(0,2)] = 1'b1;
    hv[12][idx(1,0)] = 1'b1; hv[12][idx(2,4)] = 1'b1; hv[12][idx(3,1)] = 1'b1;
    hv[14][idx(4,3)] = 1'b1;
    run_frame();
    for (int c = 0; c < 12; c++) chk($sformatf("R5 one layer bx%0d", c), pr[c], 0);
    chk("R6 masked bx12", pr[12], 0);
    chk("R6 masked bx13", pr[13], 0);
    chk("R5 fire bx14", pr[14], 1);
    chk("R5 layers", lyr[14], 3);
    chk("R5 key", kwr[14], 45);
    chk("R5 bx_o", bxr[14], 14);
    chk("R8 d0 result", rs[14], 1);
    chk("R8 d0 quality", ql[14], 3);
  endtask

  task automatic t_kinds();
    clear_hv();
    for (int l = 0; l < 3; l++) hv[3][idx(l,2)] = 1'b1;
    cfg(1, 2, 4, 1, 1, 0);
    run_frame();
    for (int c = 0; c < 12; c++) chk($sformatf("R7 acc blocks bx%0d", c), pr[c], 0);
    cfg(0, 2, 4, 1, 1, 0);
    run_frame();
    chk("R7 coll fires", pr[3], 1);
    chk("R7 coll layers", lyr[3], 3);
    hv[3][idx(3,2)] = 1'b1;
    cfg(1, 2, 4, 1, 1, 0);
    run_frame();
    chk("R7 acc fires", pr[3], 1);
    chk("R7 acc layers", lyr[3], 4);
    chk("R7 acc before", pr[2], 0);
  endtask

  task automatic t_drift();
    clear_hv();
    hv[5][idx(0,1)] = 1'b1; hv[5][idx(1,1)] = 1'b1;
    hv[6][idx(2,1)] = 1'b1; hv[7][idx(3,1)] = 1'b1;
    cfg(0, 2, 7, 4, 7, 2);
    run_frame();
    chk("R8 pretrig", pr[5], 1);
    chk("R8 layers", lyr[5], 2);
    chk("R10 blocked bx6", pr[6], 0);
    chk("R10 blocked bx7", pr[7], 0);
    chk("R8 no early bx5", rs[5], 0);
    chk("R8 no early bx6", rs[6], 0);
    chk("R8 result", rs[7], 1);
    chk("R8 quality", ql[7], 4);
    cfg(0, 2, 7, 5, 7, 2);
    run_frame();
    chk("R9 result", rs[7], 1);
    chk("R9 quality", ql[7], 0);
  endtask

  task automatic t_block();
    clear_hv();
    hv[5][idx(0,0)] = 1'b1; hv[5][idx(1,0)] = 1'b1;
    cfg(0, 2, 7, 2, 7, 3);
    run_frame();
    chk("R10 first", pr[5], 1);
    for (int c = 6; c <= 8; c++) chk($sformatf("R10 held bx%0d", c), pr[c], 0);
    chk("R10 next", pr[9], 1);
    chk("R8 d3 none bx7", rs[7], 0);
    chk("R8 d3 result", rs[8], 1);
    chk("R8 d3 quality", ql[8], 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_stretch();
    t_continuation();
    t_dead_time();
    t_range();
    t_layers_mask();
    t_kinds();
    t_drift();
    t_block();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule